// File: doc/BRIEF.md
# UDP/IPv4 Transmit Frame Builder

This block assembles one outgoing Ethernet frame each time a scheduler grants a logical link. On a start pulse it captures that link's configuration: source MAC, the upper four bytes of the destination MAC, a 16-bit link identifier, the payload length and the payload start address. It then produces the frame body as a byte stream. The body is the destination MAC with the link identifier in its two low-order bytes, the source MAC, the type 0x0800, a 20-byte IPv4 header, an 8-byte UDP header, the payload bytes, and zero padding.

Payload bytes come from an external synchronous memory. An address presented in one cycle returns its data in the next. The IPv4 addresses, UDP ports and TTL are parameters. The IPv4 header checksum is computed in one cycle between the start and the first header byte. Preamble, start delimiter, FCS and the PHY side belong to the downstream MAC.

The output is a valid/ready stream. A byte moves when tx_valid and tx_ready are both high at a rising clock edge. While tx_ready is low, the pending byte and its markers are held unchanged. Bytes are never dropped or repeated. The block may insert idle cycles only between frames.

Top module: `udp_frame_builder`

## Requirements
- R1: Body bytes 0..5 are the destination MAC: cfg_dst_hi from its most significant byte down, then cfg_link_id high byte, then its low byte. Bytes 6..11 are cfg_src_mac, most significant byte first. Bytes 12..13 are 0x08, 0x00.
- R2: Bytes 14..33 form an IPv4 header. The fields are, in order: 0x45, 0x00, total length = 28 + payload length (big-endian), identification 0x0000, flags/fragment 0x4000, TTL, protocol 0x11, header checksum, source IP, destination IP. The checksum is the one's complement of the one's-complement sum of the other nine 16-bit header words.
- R3: Bytes 34..41 form the UDP header: source port, destination port, length = 8 + payload length, checksum 0x0000. All fields are big-endian.
- R4: Payload byte k (k from 0) is memory[(cfg_addr + k) mod 2^ADDR_W]. mem_addr is read in a cycle and mem_data is expected in the next.
- R5: A frame carries max(60, 42 + length) bytes. Any bytes after the payload are 0x00.
- R6: tx_first is high only with the first byte of a frame. tx_last is high only with its final byte.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_first and tx_last stay unchanged into the next cycle.
- R8: A start whose length is 0 or greater than 1472 raises err for exactly the following cycle. No byte is sent for it.
- R9: done is high for exactly the one cycle after the edge that accepts the byte carrying tx_last.
- R10: busy is high from the cycle after an accepted start until done. A start arriving while busy is ignored entirely.
- R11: After reset, tx_valid, busy, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Grant for one frame, sampled when idle |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_dst_hi | input | 32 | Upper four bytes of the destination MAC |
| cfg_link_id | input | 16 | Logical link identifier, placed in the destination MAC's low bytes |
| cfg_len | input | LEN_W | Payload length in bytes |
| cfg_addr | input | ADDR_W | Payload start address in memory |
| busy | output | 1 | Frame in progress |
| err | output | 1 | One-cycle pulse: rejected length |
| done | output | 1 | One-cycle pulse: frame complete |
| mem_rd | output | 1 | Payload memory read enable |
| mem_addr | output | ADDR_W | Payload memory address |
| mem_data | input | 8 | Payload memory data, one cycle after address |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Last byte of frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench sets ADDR_W to 8, so the payload memory has 256 entries. A maximum-length payload then wraps the address several times. This shows that the address arithmetic is modulo the parameter width and does not saturate. LEN_W keeps its default of 11. Lengths 0 and 1473 are therefore both representable and both rejected, and the 17/18 byte boundary between padded and unpadded frames is exercised on each side. Random ready patterns run across the header, the payload and the padding transitions.

// File: rtl/udpfb_pkg.sv
package udpfb_pkg;
  localparam int HDR_BYTES = 42;
  localparam int IP_HDR_PLUS_UDP = 28;
  localparam int UDP_HDR = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_SEND = 2'd2
  } fb_state_t;
endpackage

// File: rtl/udpfb_len_chk.sv
module udpfb_len_chk #(
  parameter int LEN_W       = 11,
  parameter int IDX_W       = 11,
  parameter int MAX_PAYLOAD = 1472,
  parameter int MIN_FRAME   = 64,
  parameter int FCS_BYTES   = 4
) (
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic [IDX_W-1:0] body_len
);
  localparam int MIN_BODY = MIN_FRAME - FCS_BYTES;
  localparam int PAD_EDGE = MIN_BODY - udpfb_pkg::HDR_BYTES;

  logic [IDX_W-1:0] raw;

  always_comb begin
    raw = IDX_W'(udpfb_pkg::HDR_BYTES) + IDX_W'(len);
    ok = (len != '0) && (int'(len) <= MAX_PAYLOAD);
    if (int'(len) < PAD_EDGE) body_len = IDX_W'(MIN_BODY);
    else                      body_len = raw;
  end
endmodule

// File: rtl/udpfb_csum.sv
module udpfb_csum #(
  parameter logic [31:0] SRC_IP = 32'hC0A80A01,
  parameter logic [31:0] DST_IP = 32'hC0A80AFF,
  parameter logic [7:0]  TTL    = 8'd64
) (
  input  logic [15:0] ip_len,
  output logic [15:0] csum
);
  logic [19:0] acc;
  logic [16:0] fold1;
  logic [16:0] fold2;

  always_comb begin
    acc = 20'h04500 + 20'(ip_len) + 20'h04000 + 20'({TTL, 8'h11})
        + 20'(SRC_IP[31:16]) + 20'(SRC_IP[15:0])
        + 20'(DST_IP[31:16]) + 20'(DST_IP[15:0]);
    fold1 = 17'(acc[15:0]) + 17'(acc[19:16]);
    fold2 = 17'(fold1[15:0]) + 17'(fold1[16]);
    csum  = ~fold2[15:0];
  end
endmodule

// File: rtl/udpfb_hdr.sv
module udpfb_hdr #(
  parameter logic [31:0] SRC_IP   = 32'hC0A80A01,
  parameter logic [31:0] DST_IP   = 32'hC0A80AFF,
  parameter logic [15:0] SRC_PORT = 16'd5000,
  parameter logic [15:0] DST_PORT = 16'd6000,
  parameter logic [7:0]  TTL      = 8'd64
) (
  input  logic [5:0]  sel,
  input  logic [31:0] dst_hi,
  input  logic [15:0] link_id,
  input  logic [47:0] src_mac,
  input  logic [15:0] ip_len,
  input  logic [15:0] udp_len,
  input  logic [15:0] ip_csum,
  output logic [7:0]  hbyte
);
  localparam int NB = udpfb_pkg::HDR_BYTES;

  logic [NB*8-1:0] vec;

  always_comb begin
    vec = {dst_hi, link_id, src_mac, 16'h0800,
           8'h45, 8'h00, ip_len, 16'h0000, 16'h4000, TTL, 8'h11, ip_csum,
           SRC_IP, DST_IP,
           SRC_PORT, DST_PORT, udp_len, 16'h0000};
    if (int'(sel) < NB) hbyte = vec[(NB-1-int'(sel))*8 +: 8];
    else                hbyte = 8'h00;
  end
endmodule

// File: rtl/udp_frame_builder.sv
module udp_frame_builder #(
  parameter int          LEN_W       = 11,
  parameter int          ADDR_W      = 12,
  parameter int          MAX_PAYLOAD = 1472,
  parameter int          MIN_FRAME   = 64,
  parameter int          FCS_BYTES   = 4,
  parameter logic [31:0] SRC_IP      = 32'hC0A80A01,
  parameter logic [31:0] DST_IP      = 32'hC0A80AFF,
  parameter logic [15:0] SRC_PORT    = 16'd5000,
  parameter logic [15:0] DST_PORT    = 16'd6000,
  parameter logic [7:0]  TTL         = 8'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [47:0]       cfg_src_mac,
  input  logic [31:0]       cfg_dst_hi,
  input  logic [15:0]       cfg_link_id,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              busy,
  output logic              err,
  output logic              done,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  input  logic              tx_ready
);
  import udpfb_pkg::*;

  localparam int IDX_W = $clog2(HDR_BYTES + MAX_PAYLOAD + 1);

  fb_state_t         state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  body_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic [47:0]       src_q;
  logic [31:0]       dhi_q;
  logic [15:0]       lid_q;
  logic [15:0]       csum_q;

  logic              len_ok;
  logic [IDX_W-1:0]  body_len;
  logic [15:0]       ip_len;
  logic [15:0]       udp_len;
  logic [15:0]       csum_w;
  logic [7:0]        hdr_byte;
  logic [7:0]        next_byte;
  logic [IDX_W-1:0]  pay_end;
  logic              load;
  logic              accept_last;
  logic [IDX_W-1:0]  idx_next;
  logic [IDX_W-1:0]  pay_off;

  udpfb_len_chk #(
    .LEN_W(LEN_W), .IDX_W(IDX_W), .MAX_PAYLOAD(MAX_PAYLOAD),
    .MIN_FRAME(MIN_FRAME), .FCS_BYTES(FCS_BYTES)
  ) u_len (
    .len(cfg_len), .ok(len_ok), .body_len(body_len)
  );

  assign ip_len  = 16'(len_q) + 16'(IP_HDR_PLUS_UDP);
  assign udp_len = 16'(len_q) + 16'(UDP_HDR);

  udpfb_csum #(.SRC_IP(SRC_IP), .DST_IP(DST_IP), .TTL(TTL)) u_csum (
    .ip_len(ip_len), .csum(csum_w)
  );

  udpfb_hdr #(
    .SRC_IP(SRC_IP), .DST_IP(DST_IP), .SRC_PORT(SRC_PORT),
    .DST_PORT(DST_PORT), .TTL(TTL)
  ) u_hdr (
    .sel(idx[5:0]), .dst_hi(dhi_q), .link_id(lid_q), .src_mac(src_q),
    .ip_len(ip_len), .udp_len(udp_len), .ip_csum(csum_q), .hbyte(hdr_byte)
  );

  // Byte selection and the look-ahead payload address.
  always_comb begin
    pay_end     = IDX_W'(HDR_BYTES) + IDX_W'(len_q);
    load        = (state == ST_SEND) && (!tx_valid || tx_ready) && (idx < body_q);
    accept_last = tx_valid && tx_ready && tx_last;
    idx_next    = load ? idx + IDX_W'(1) : idx;
    if (idx_next >= IDX_W'(HDR_BYTES)) pay_off = idx_next - IDX_W'(HDR_BYTES);
    else                               pay_off = '0;
    if (idx < IDX_W'(HDR_BYTES)) next_byte = hdr_byte;
    else if (idx < pay_end)      next_byte = mem_data;
    else                         next_byte = 8'h00;
  end

  assign mem_addr = base_q + ADDR_W'(pay_off);
  assign mem_rd   = (state == ST_SEND);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      body_q   <= '0;
      len_q    <= '0;
      base_q   <= '0;
      src_q    <= '0;
      dhi_q    <= '0;
      lid_q    <= '0;
      csum_q   <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      err  <= 1'b0;
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (len_ok) begin
              len_q  <= cfg_len;
              body_q <= body_len;
              base_q <= cfg_addr;
              src_q  <= cfg_src_mac;
              dhi_q  <= cfg_dst_hi;
              lid_q  <= cfg_link_id;
              idx    <= '0;
              state  <= ST_CALC;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_CALC: begin
          csum_q <= csum_w;
          state  <= ST_SEND;
        end
        ST_SEND: begin
          if (load) begin
            tx_data  <= next_byte;
            tx_valid <= 1'b1;
            tx_first <= (idx == '0);
            tx_last  <= (idx == body_q - IDX_W'(1));
            idx      <= idx_next;
          end else if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_first <= 1'b0;
            tx_last  <= 1'b0;
          end
          if (accept_last) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udpfb_chk.sv
module udpfb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       err,
  input logic       done,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_first,
  input logic       tx_last,
  input logic       tx_ready
);
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                 $stable(tx_first) && $stable(tx_last)));

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !tx_valid));

  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tx_valid));

  a_r6_markers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_first || tx_last) |-> tx_valid);

  a_r6_first_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_first && tx_last));
endmodule

bind udp_frame_builder udpfb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .done(done),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
  .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/sim_udp_frame_builder.sv
module sim_udp_frame_builder;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W  = 11;
  localparam int ADDR_W = 8;
  localparam logic [31:0] SIP = 32'hC0A80A01;
  localparam logic [31:0] DIP = 32'hC0A80AFF;
  localparam logic [15:0] SPORT = 16'd5000;
  localparam logic [15:0] DPORT = 16'd6000;
  localparam logic [7:0]  TTLV = 8'd64;

  typedef struct {
    logic [7:0] b;
    logic       f;
    logic       l;
    int         req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [47:0] cfg_src_mac = '0;
  logic [31:0] cfg_dst_hi = '0;
  logic [15:0] cfg_link_id = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic busy, err, done, mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data, tx_data;
  logic tx_valid, tx_first, tx_last;
  logic tx_ready = 1'b1;

  logic [7:0] mem [256];
  logic [7:0] mem_q = '0;
  int checks = 0, errors = 0, cycles = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  item_t q[$];
  logic exp_done = 1'b0;
  logic mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_frame_builder #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .SRC_IP(SIP), .DST_IP(DIP),
    .SRC_PORT(SPORT), .DST_PORT(DPORT), .TTL(TTLV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src_mac(cfg_src_mac),
    .cfg_dst_hi(cfg_dst_hi), .cfg_link_id(cfg_link_id), .cfg_len(cfg_len),
    .cfg_addr(cfg_addr), .busy(busy), .err(err), .done(done), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
    .tx_ready(tx_ready));

  always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];
  assign mem_data = mem_q;

  function automatic string rname(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 8: return "R8"; 9: return "R9";
      10: return "R10"; 11: return "R11"; default: return "R7";
    endcase
  endfunction

  task automatic chk(int r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rname(r), act, exp);
    end
  endtask

  function automatic logic [15:0] ip_sum(int len);
    logic [31:0] s;
    s = 32'h4500 + 32'(len + 28) + 32'h4000 + {16'h0, TTLV, 8'h11}
      + SIP[31:16] + SIP[15:0] + DIP[31:16] + DIP[15:0];
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return ~s[15:0];
  endfunction

  // Driver: pushes the expected frame into the scoreboard and pulses start.
  task automatic send(logic [47:0] src, logic [31:0] dhi, logic [15:0] lid,
                      int len, logic [ADDR_W-1:0] addr);
    logic [7:0] h[42];
    logic [15:0] cs, il, ul;
    int body;
    bit good;
    good = (len >= 1) && (len <= 1472);
    if (good) begin
      cs = ip_sum(len); il = 16'(len + 28); ul = 16'(len + 8);
      for (int i = 0; i < 4; i++) h[i] = dhi[31-8*i -: 8];
      h[4] = lid[15:8]; h[5] = lid[7:0];
      for (int i = 0; i < 6; i++) h[6+i] = src[47-8*i -: 8];
      h[12] = 8'h08; h[13] = 8'h00; h[14] = 8'h45; h[15] = 8'h00;
      h[16] = il[15:8]; h[17] = il[7:0]; h[18] = 0; h[19] = 0;
      h[20] = 8'h40; h[21] = 0; h[22] = TTLV; h[23] = 8'h11;
      h[24] = cs[15:8]; h[25] = cs[7:0];
      for (int i = 0; i < 4; i++) begin
        h[26+i] = SIP[31-8*i -: 8]; h[30+i] = DIP[31-8*i -: 8];
      end
      h[34] = SPORT[15:8]; h[35] = SPORT[7:0]; h[36] = DPORT[15:8]; h[37] = DPORT[7:0];
      h[38] = ul[15:8]; h[39] = ul[7:0]; h[40] = 0; h[41] = 0;
      body = (42 + len < 60) ? 60 : 42 + len;
      for (int k = 0; k < body; k++) begin
        item_t it;
        it.f = (k == 0); it.l = (k == body - 1);
        if (k < 42) begin
          it.b = h[k]; it.req = (k < 14) ? 1 : (k < 34) ? 2 : 3;
        end else if (k < 42 + len) begin
          it.b = mem[8'(int'(addr) + k - 42)]; it.req = 4;
        end else begin
          it.b = 8'h00; it.req = 5;
        end
        q.push_back(it);
      end
    end
    @(posedge clk); #1;
    start = 1'b1; cfg_src_mac = src; cfg_dst_hi = dhi; cfg_link_id = lid;
    cfg_len = LEN_W'(len); cfg_addr = addr;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    if (good) begin
      chk(10, {31'h0, busy}, 32'h1);   // R10 busy after accepted start
      chk(8, {31'h0, err}, 32'h0);
    end else begin
      chk(8, {31'h0, err}, 32'h1);     // R8 error pulse on rejected length
      chk(8, {31'h0, busy}, 32'h0);
      @(negedge clk);
      chk(8, {31'h0, err}, 32'h0);     // R8 pulse lasts one cycle
    end
  endtask

  task automatic wait_idle();
    while (busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Ready pattern driven just after each rising edge.
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rdy_mode == 0) tx_ready = 1'b1;
    else if (rdy_mode == 1) tx_ready = lfsr[0];
    else tx_ready = lfsr[0] & lfsr[3];
  end

  // Monitor: compares each accepted byte against the scoreboard.
  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      if (exp_done || done) chk(9, {31'h0, done}, {31'h0, exp_done});
      exp_done = 1'b0;
      if (tx_valid && tx_ready) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 actual unexpected byte %0h expected none", tx_data);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(e.req, {24'h0, tx_data}, {24'h0, e.b});
          chk(6, {30'h0, tx_first, tx_last}, {30'h0, e.f, e.l});
          if (tx_last) exp_done = 1'b1;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(11, {28'h0, tx_valid, busy, done, err}, 32'h0);  // R11 reset state
    rst_n = 1'b1;
    @(negedge clk);
    chk(11, {28'h0, tx_valid, busy, done, err}, 32'h0);
    mon_on = 1'b1;

    send(48'h0200_0000_0001, 32'h0300_0000, 16'h0001, 1, 8'h10);   // R5 most padding
    wait_idle();
    send(48'h0200_0000_0002, 32'h0300_0001, 16'hA5C3, 17, 8'h40);  // R5 one pad byte
    wait_idle();
    send(48'h0200_0000_0003, 32'h0300_0002, 16'h0102, 18, 8'hF8);  // R5 no pad, R4 wrap
    wait_idle();
    rdy_mode = 1;
    send(48'h0A0B_0C0D_0E0F, 32'h1122_3344, 16'hBEEF, 100, 8'h80); // R7 random stall
    wait_idle();
    rdy_mode = 2;
    send(48'h0200_0000_0005, 32'h0300_0004, 16'h7FFF, 3, 8'h00);   // R7 stall in padding
    wait_idle();
    send(48'h0200_0000_0006, 32'h0300_0005, 16'h0006, 0, 8'h00);   // R8 zero length
    repeat (5) @(negedge clk);
    chk(8, {31'h0, tx_valid}, 32'h0);
    send(48'h0200_0000_0007, 32'h0300_0006, 16'h0007, 1473, 8'h00); // R8 too long
    repeat (5) @(negedge clk);
    chk(8, {31'h0, tx_valid}, 32'h0);
    rdy_mode = 1;
    send(48'h0200_0000_0008, 32'hFFEE_DDCC, 16'h8001, 1472, 8'h33); // R4 max, wraps
    wait_idle();
    rdy_mode = 0;
    send(48'h0200_0000_0009, 32'h0300_0008, 16'h0909, 30, 8'h05);  // R10 second start
    repeat (10) @(posedge clk);
    #1; start = 1'b1; cfg_len = LEN_W'(5); cfg_link_id = 16'hDEAD;
    @(posedge clk); #1; start = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(10, {31'h0, tx_valid}, 32'h0);   // R10 ignored start sent nothing
    chk(10, 32'(q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL R7 actual watchdog expired expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule